// File: doc/BRIEF.md
# Fence and Wait Synchronization Unit

This unit sits beside the command decoder of a command processor and carries out its synchronization commands. It holds a bank of sixteen 32-bit registers that the host reads and writes through a simple port. A fence command writes a chosen value, typically a command-buffer sequence number, into one of these registers. The write happens only once every piece of previously dispatched work has completed. A wait command holds back the command stream until a chosen register meets a comparison against a value. Either the host or a later fence can satisfy that comparison.

The decoder presents one command at a time. The command is taken on any clock edge where `cmd_valid` is high and `cmd_stall` is low. Work dispatched to the rest of the pipeline is counted up through `work_dispatch`, and its completion is counted down through `work_done`. A fence may also raise a level interrupt. The interrupt is held in a sticky status bit until the host clears it. A pipeline flush is a fence to register 0 with a new sequence id, followed by a wait on register 0 for that same id.

Top module: `sync_fence_unit`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), all sixteen registers read 0, `irq` is 0, `cmd_stall` is 0 and the outstanding-work count is zero.
- R2: A host write to `host_addr` 0..15 stores `host_wdata` in that register. `host_rdata` returns register `host_addr` combinationally. Address 16 reads the interrupt status in bit 0 with every other bit 0. Addresses 17..31 read 0.
- R3: A fence (opcode 1) accepted while no work is outstanding writes `cmd_value` into register `cmd_reg_idx` at the accepting edge, and `cmd_stall` stays 0.
- R4: A fence accepted while work is outstanding sets `cmd_stall`. Its register write is deferred until the count is zero, and lands at the first edge where the registered count is already zero. `cmd_stall` falls at that same edge. Commands presented while `cmd_stall` is 1 are not accepted and have no effect.
- R5: A wait (opcode 2) whose condition already holds when it is accepted completes at once, and `cmd_stall` stays 0.
- R6: A wait whose condition fails sets `cmd_stall`. The stall lasts until the register satisfies the condition, and `cmd_stall` falls one edge after the edge that made it true, such as a host write.
- R7: `cmd_cmp_mode` selects the comparison of register against value: 0 equal, 1 not equal, 2 unsigned less-than, 3 unsigned greater-or-equal. Codes 4..7 act as equal.
- R8: When a fence write and a host write target the same register at the same edge, the fence value is stored. When they target different registers, both writes are stored.
- R9: A fence with `cmd_irq_en` = 1 sets the sticky interrupt status when its write lands, and `irq` equals that status. A host write to address 16 with bit 0 = 1 clears it, and with bit 0 = 0 leaves it unchanged. A set and a clear at the same edge leave it set.
- R10: `work_dispatch` and `work_done` together leave the outstanding count unchanged. `work_done` while the count is zero is ignored.
- R11: Opcodes 0 and 3 are accepted with no effect on registers, `irq` or `cmd_stall`.
- R12: A flush, made of a fence to register 0 followed by a wait on register 0 for the same value, leaves register 0 holding that value with no stall left once the outstanding work is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present from the decoder |
| cmd_opcode | input | 2 | 0 no-op, 1 fence, 2 wait, 3 no-op |
| cmd_reg_idx | input | 4 | Target register index |
| cmd_cmp_mode | input | 3 | Wait comparison selector |
| cmd_irq_en | input | 1 | Fence raises interrupt when it lands |
| cmd_value | input | 32 | Fence value or wait operand |
| cmd_stall | output | 1 | Command stream held; no command accepted |
| work_dispatch | input | 1 | One unit of work dispatched this cycle |
| work_done | input | 1 | One unit of work completed this cycle |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 5 | Host address: 0..15 registers, 16 interrupt status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| irq | output | 1 | Level interrupt |

## Verification
Commands, host writes and work pulses are driven on the falling edge and take effect at the next rising edge. A fence that has nothing to wait for, and a wait that already holds, therefore show their result one falling edge after they are presented. A deferred fence lands one edge after the count reaches zero, and a blocked wait drops `cmd_stall` one edge after the releasing write. The bench samples at the falling edge right after the triggering edge, where the old value must still be visible, and again one cycle later, where the new value must be visible. This pins down the exact cycle and not just the eventual outcome. Commands sent while the unit is stalled are checked later through the host read port, to show that they never landed.

// File: rtl/sync_fence_pkg.sv
// Shared types and constants for the fence/wait synchronization unit.
// Assumes a 32-bit data path and a power-of-two register count.
package sync_fence_pkg;
    localparam int DATA_W = 32;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_FENCE = 2'd1,
        OP_WAIT  = 2'd2,
        OP_SPARE = 2'd3
    } sync_op_e;

    localparam logic [MODE_W-1:0] CMP_EQ = 3'd0;
    localparam logic [MODE_W-1:0] CMP_NE = 3'd1;
    localparam logic [MODE_W-1:0] CMP_LT = 3'd2;
    localparam logic [MODE_W-1:0] CMP_GE = 3'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FENCE = 2'd1,
        ST_WAIT  = 2'd2
    } sync_state_e;
endpackage

// File: rtl/sync_wait_cmp.sv
// Combinational comparator for wait conditions: checks a register value
// against an operand under a selectable mode. Unused mode codes fall back
// to equality. Assumes unsigned operands.
module sync_wait_cmp
    import sync_fence_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     lhs,
    input  logic [DW-1:0]     rhs,
    output logic              ok
);
    // Evaluate the selected relation.
    always_comb begin
        case (mode)
            CMP_NE:  ok = (lhs != rhs);
            CMP_LT:  ok = (lhs <  rhs);
            CMP_GE:  ok = (lhs >= rhs);
            default: ok = (lhs == rhs);
        endcase
    end
endmodule

// File: rtl/sync_work_counter.sv
// Counts dispatched-but-unfinished work. Increments on dispatch and
// decrements on done. Simultaneous pulses cancel. Done at zero is ignored
// and dispatch at full scale is ignored. Reports when nothing is outstanding.
module sync_work_counter #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dispatch,
    input  logic done,
    output logic idle
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Track outstanding work with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({dispatch, done})
                2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                2'b01:   if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign idle = (cnt_q == '0);

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && done && !dispatch) |=> (cnt_q == '0));

    // R10
    cancel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dispatch && done) |=> $stable(cnt_q));
endmodule

// File: rtl/sync_reg_bank.sv
// Bank of host-visible synchronization registers. Has two write sources
// (host and fence) and two combinational read ports (host and compare).
// A fence write takes priority over a host write to the same register.
module sync_reg_bank
    import sync_fence_pkg::*;
#(
    parameter  int NREG = 16,
    parameter  int DW   = DATA_W,
    localparam int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_idx,
    input  logic [DW-1:0] host_data,
    input  logic          fence_we,
    input  logic [AW-1:0] fence_idx,
    input  logic [DW-1:0] fence_data,
    input  logic [AW-1:0] rd_a_idx,
    output logic [DW-1:0] rd_a_data,
    input  logic [AW-1:0] rd_b_idx,
    output logic [DW-1:0] rd_b_data
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;
        // Store one register; the fence source wins on a same-index collision.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (fence_we && fence_idx == AW'(g))
                q <= fence_data;
            else if (host_we && host_idx == AW'(g))
                q <= host_data;
        end
        assign regs[g] = q;
    end

    assign rd_a_data = regs[rd_a_idx];
    assign rd_b_data = regs[rd_b_idx];

    // R8
    fence_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_we |=> (regs[$past(fence_idx)] == $past(fence_data)));
endmodule

// File: rtl/sync_fence_unit.sv
// Fence/wait synchronization unit for a command processor. Takes one
// command at a time from the decoder. A fence defers its register write
// until no dispatched work is outstanding. A wait holds the stream until
// a register comparison holds. Drives a sticky level interrupt.
// Assumes the decoder holds its command while cmd_stall is high.
module sync_fence_unit
    import sync_fence_pkg::*;
#(
    parameter  int NREG  = 16,
    parameter  int DW    = DATA_W,
    parameter  int CNT_W = 8,
    localparam int AW    = $clog2(NREG),
    localparam int HAW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_opcode,
    input  logic [AW-1:0]     cmd_reg_idx,
    input  logic [MODE_W-1:0] cmd_cmp_mode,
    input  logic              cmd_irq_en,
    input  logic [DW-1:0]     cmd_value,
    output logic              cmd_stall,
    input  logic              work_dispatch,
    input  logic              work_done,
    input  logic              host_we,
    input  logic [HAW-1:0]    host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              irq
);
    sync_state_e       st_q;
    logic [AW-1:0]     p_idx_q;
    logic [MODE_W-1:0] p_mode_q;
    logic              p_irq_q;
    logic [DW-1:0]     p_val_q;
    logic              irq_q;

    logic              accept, is_fence, is_wait, work_idle, cmp_ok;
    logic              fence_fire, host_reg_we, host_irq_clr;
    logic [AW-1:0]     act_idx;
    logic [MODE_W-1:0] act_mode;
    logic              act_irq;
    logic [DW-1:0]     act_val, cmp_lhs, host_reg_data;

    assign accept   = cmd_valid && (st_q == ST_IDLE);
    assign is_fence = (cmd_opcode == OP_FENCE);
    assign is_wait  = (cmd_opcode == OP_WAIT);

    // Select live command fields when idle and latched fields when pending.
    always_comb begin
        if (st_q == ST_IDLE) begin
            act_idx  = cmd_reg_idx;
            act_mode = cmd_cmp_mode;
            act_irq  = cmd_irq_en;
            act_val  = cmd_value;
        end else begin
            act_idx  = p_idx_q;
            act_mode = p_mode_q;
            act_irq  = p_irq_q;
            act_val  = p_val_q;
        end
    end

    assign fence_fire   = work_idle && ((accept && is_fence) || (st_q == ST_FENCE));
    assign host_reg_we  = host_we && !host_addr[AW];
    assign host_irq_clr = host_we && (host_addr == HAW'(NREG)) && host_wdata[0];

    sync_work_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .dispatch(work_dispatch), .done(work_done), .idle(work_idle)
    );

    sync_reg_bank #(.NREG(NREG), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_reg_we), .host_idx(host_addr[AW-1:0]), .host_data(host_wdata),
        .fence_we(fence_fire), .fence_idx(act_idx), .fence_data(act_val),
        .rd_a_idx(host_addr[AW-1:0]), .rd_a_data(host_reg_data),
        .rd_b_idx(act_idx), .rd_b_data(cmp_lhs)
    );

    sync_wait_cmp #(.DW(DW)) u_cmp (
        .mode(act_mode), .lhs(cmp_lhs), .rhs(act_val), .ok(cmp_ok)
    );

    // Sequence commands: latch on acceptance, stay pending until released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            p_idx_q  <= '0;
            p_mode_q <= '0;
            p_irq_q  <= 1'b0;
            p_val_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (accept) begin
                    p_idx_q  <= cmd_reg_idx;
                    p_mode_q <= cmd_cmp_mode;
                    p_irq_q  <= cmd_irq_en;
                    p_val_q  <= cmd_value;
                    if (is_fence && !work_idle) st_q <= ST_FENCE;
                    else if (is_wait && !cmp_ok) st_q <= ST_WAIT;
                end
                ST_FENCE: if (work_idle) st_q <= ST_IDLE;
                ST_WAIT:  if (cmp_ok)    st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // Hold the sticky interrupt status; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     irq_q <= 1'b0;
        else if (fence_fire && act_irq) irq_q <= 1'b1;
        else if (host_irq_clr)          irq_q <= 1'b0;
    end

    // Decode the host read address.
    always_comb begin
        if (!host_addr[AW])                  host_rdata = host_reg_data;
        else if (host_addr == HAW'(NREG))    host_rdata = {{(DW-1){1'b0}}, irq_q};
        else                                 host_rdata = '0;
    end

    assign cmd_stall = (st_q != ST_IDLE);
    assign irq       = irq_q;

    // R4
    fence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FENCE && !work_idle) |=> cmd_stall);

    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && !cmp_ok) |=> cmd_stall);

    // R5
    wait_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_wait && cmp_ok) |=> !cmd_stall);

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !host_irq_clr) |=> irq);

    // R3
    fence_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_fence && work_idle) |=> !cmd_stall);
endmodule

// File: tb/sync_fence_unit_tb.sv
// Directed bench for the fence/wait unit: one task per scenario, each
// checking its own results at the falling edge.
module sync_fence_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_opcode = '0;
    logic [3:0]  cmd_reg_idx = '0;
    logic [2:0]  cmd_cmp_mode = '0;
    logic        cmd_irq_en = 1'b0;
    logic [31:0] cmd_value = '0;
    logic        cmd_stall;
    logic        work_dispatch = 1'b0;
    logic        work_done = 1'b0;
    logic        host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sync_fence_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_reg_idx(cmd_reg_idx),
        .cmd_cmp_mode(cmd_cmp_mode), .cmd_irq_en(cmd_irq_en), .cmd_value(cmd_value),
        .cmd_stall(cmd_stall), .work_dispatch(work_dispatch), .work_done(work_done),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    function automatic logic [31:0] pat(int i);
        return 32'hA500_0000 + 32'(i * 3);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(logic [1:0] op, logic [3:0] idx, logic [2:0] mode,
                        logic ie, logic [31:0] val);
        cmd_opcode = op; cmd_reg_idx = idx; cmd_cmp_mode = mode;
        cmd_irq_en = ie; cmd_value = val; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_irq_en = 1'b0;
    endtask

    task automatic hwrite(logic [4:0] a, logic [31:0] d);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(logic [4:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic pulse(logic disp, logic dn);
        work_dispatch = disp; work_done = dn;
        @(negedge clk);
        work_dispatch = 1'b0; work_done = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 stall", {31'b0, cmd_stall}, 0);
        check("R1 irq", {31'b0, irq}, 0);
        for (int i = 0; i < 17; i++) begin
            hread(5'(i), d);
            check($sformatf("R1 addr %0d", i), d, 0);
        end
    endtask

    task automatic t_host_rw;
        logic [31:0] d;
        for (int i = 0; i < 16; i++) hwrite(5'(i), pat(i));
        for (int i = 0; i < 16; i++) begin
            hread(5'(i), d);
            check($sformatf("R2 reg %0d", i), d, pat(i));
        end
        hread(5'd20, d);
        check("R2 unused addr", d, 0);
    endtask

    task automatic t_fence_now;
        logic [31:0] d;
        send(2'd1, 4'd5, 3'd0, 1'b0, 32'd303);
        check("R3 no stall", {31'b0, cmd_stall}, 0);
        hread(5'd5, d);
        check("R3 reg5", d, 32'd303);
    endtask

    task automatic t_fence_defer;
        logic [31:0] d;
        pulse(1, 0); pulse(1, 0);
        send(2'd1, 4'd7, 3'd0, 1'b0, 32'd77);
        check("R4 stall set", {31'b0, cmd_stall}, 1);
        send(2'd1, 4'd8, 3'd0, 1'b0, 32'd1);
        pulse(0, 1);
        check("R4 stall one left", {31'b0, cmd_stall}, 1);
        pulse(0, 1);
        check("R4 stall at zero edge", {31'b0, cmd_stall}, 1);
        hread(5'd7, d);
        check("R4 reg7 not yet", d, pat(7));
        @(negedge clk);
        check("R4 stall released", {31'b0, cmd_stall}, 0);
        hread(5'd7, d);
        check("R4 reg7 written", d, 32'd77);
        hread(5'd8, d);
        check("R4 stalled cmd dropped", d, pat(8));
    endtask

    task automatic t_wait_ready;
        hwrite(5'd3, 32'd10);
        send(2'd2, 4'd3, 3'd0, 1'b0, 32'd10);
        check("R5 eq holds", {31'b0, cmd_stall}, 0);
        send(2'd2, 4'd3, 3'd2, 1'b0, 32'd11);
        check("R7 lt holds", {31'b0, cmd_stall}, 0);
        send(2'd2, 4'd3, 3'd3, 1'b0, 32'd10);
        check("R7 ge holds", {31'b0, cmd_stall}, 0);
        send(2'd2, 4'd3, 3'd1, 1'b0, 32'd9);
        check("R7 ne holds", {31'b0, cmd_stall}, 0);
        send(2'd2, 4'd3, 3'd5, 1'b0, 32'd10);
        check("R7 code5 as eq", {31'b0, cmd_stall}, 0);
    endtask

    task automatic t_wait_block;
        send(2'd2, 4'd3, 3'd0, 1'b0, 32'd20);
        check("R6 stall set", {31'b0, cmd_stall}, 1);
        repeat (3) @(negedge clk);
        check("R6 stall holds", {31'b0, cmd_stall}, 1);
        hwrite(5'd3, 32'd19);
        @(negedge clk);
        check("R6 wrong value keeps stall", {31'b0, cmd_stall}, 1);
        hwrite(5'd3, 32'd20);
        check("R6 stall at write edge", {31'b0, cmd_stall}, 1);
        @(negedge clk);
        check("R6 stall released", {31'b0, cmd_stall}, 0);
        send(2'd2, 4'd3, 3'd2, 1'b0, 32'd20);
        check("R7 lt blocks", {31'b0, cmd_stall}, 1);
        hwrite(5'd3, 32'd5);
        @(negedge clk);
        check("R7 lt released", {31'b0, cmd_stall}, 0);
        send(2'd2, 4'd3, 3'd7, 1'b0, 32'd6);
        check("R7 code7 blocks", {31'b0, cmd_stall}, 1);
        hwrite(5'd3, 32'd6);
        @(negedge clk);
        check("R7 code7 released", {31'b0, cmd_stall}, 0);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        cmd_opcode = 2'd1; cmd_reg_idx = 4'd2; cmd_cmp_mode = 3'd0;
        cmd_value = 32'hF00D; cmd_valid = 1'b1;
        host_addr = 5'd2; host_wdata = 32'hBEEF; host_we = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; host_we = 1'b0;
        hread(5'd2, d);
        check("R8 fence wins", d, 32'hF00D);
        cmd_value = 32'h1234; cmd_valid = 1'b1;
        host_addr = 5'd4; host_wdata = 32'h4444; host_we = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; host_we = 1'b0;
        hread(5'd2, d);
        check("R8 fence other reg", d, 32'h1234);
        hread(5'd4, d);
        check("R8 host other reg", d, 32'h4444);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        send(2'd1, 4'd9, 3'd0, 1'b1, 32'd1);
        check("R9 irq set", {31'b0, irq}, 1);
        hread(5'd16, d);
        check("R9 status read", d, 1);
        hwrite(5'd16, 32'hFFFF_FFFE);
        check("R9 bit0 zero keeps", {31'b0, irq}, 1);
        hwrite(5'd16, 32'd1);
        check("R9 cleared", {31'b0, irq}, 0);
        cmd_opcode = 2'd1; cmd_reg_idx = 4'd9; cmd_value = 32'd2;
        cmd_irq_en = 1'b1; cmd_valid = 1'b1;
        host_addr = 5'd16; host_wdata = 32'd1; host_we = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_irq_en = 1'b0; host_we = 1'b0;
        check("R9 set beats clear", {31'b0, irq}, 1);
        hwrite(5'd16, 32'd1);
        check("R9 cleared again", {31'b0, irq}, 0);
    endtask

    task automatic t_counter;
        logic [31:0] d;
        pulse(1, 1);
        send(2'd1, 4'd10, 3'd0, 1'b0, 32'd1);
        check("R10 cancel at zero", {31'b0, cmd_stall}, 0);
        pulse(0, 1);
        pulse(1, 0);
        send(2'd1, 4'd10, 3'd0, 1'b0, 32'd2);
        check("R10 done at zero ignored", {31'b0, cmd_stall}, 1);
        pulse(1, 1);
        @(negedge clk);
        check("R10 cancel keeps one", {31'b0, cmd_stall}, 1);
        hread(5'd10, d);
        check("R10 reg10 held", d, 32'd1);
        pulse(0, 1);
        @(negedge clk);
        check("R10 released", {31'b0, cmd_stall}, 0);
        hread(5'd10, d);
        check("R10 reg10 written", d, 32'd2);
    endtask

    task automatic t_nop;
        logic [31:0] d;
        send(2'd0, 4'd1, 3'd0, 1'b1, 32'hDEAD);
        send(2'd3, 4'd1, 3'd0, 1'b1, 32'hDEAD);
        check("R11 no stall", {31'b0, cmd_stall}, 0);
        check("R11 no irq", {31'b0, irq}, 0);
        hread(5'd1, d);
        check("R11 reg1 kept", d, pat(1));
    endtask

    task automatic t_flush;
        logic [31:0] d;
        pulse(1, 0);
        send(2'd1, 4'd0, 3'd0, 1'b0, 32'd5);
        check("R12 fence pending", {31'b0, cmd_stall}, 1);
        pulse(0, 1);
        @(negedge clk);
        check("R12 fence landed", {31'b0, cmd_stall}, 0);
        send(2'd2, 4'd0, 3'd0, 1'b0, 32'd5);
        check("R12 wait passes", {31'b0, cmd_stall}, 0);
        hread(5'd0, d);
        check("R12 reg0 id", d, 32'd5);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_host_rw;
        t_fence_now;
        t_fence_defer;
        t_wait_ready;
        t_wait_block;
        t_collide;
        t_irq;
        t_counter;
        t_nop;
        t_flush;
        summary;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary;
    end
endmodule